// File: doc/BRIEF.md
# Fuse Controller Command and Status Register

This block is the control/status word of a one-time-programmable fuse controller. Software reaches one register through three word offsets: a plain read/write view, a view that only sets the bits written as 1, and a view that only clears the bits written as 1. The word holds a fuse address, a busy flag, a sticky error flag, a shadow-reload request flag and an unlock key that arms exactly one programming operation.

The data side of the controller presents access requests: shadow read, shadow write, fuse read and fuse program. Lock information for the addressed word comes from outside the block. The block checks every request against the busy, error, key and lock state. It either hands the request to the programming engine with a one-cycle start pulse, sets the error flag, or ignores it. Reads of read-locked words get a fixed poison pattern in place of array data. The engine reports completion with a done pulse, which releases busy and the reload flag.

Top module: `otpc_ctrl`

## Requirements
- R1: After reset the control word reads 0: address 0, busy, error and reload flags clear, and the key not armed.
- R2: A write at byte offset 0x0 replaces the word, a write at 0x4 ORs the written bits in, and a write at 0x8 clears the written 1-bits. Writes at any other offset have no effect. The address field is bits [7:0].
- R3: The word reads back with busy at bit 8, error at bit 9, reload at bit 10, and bits [31:16] equal to 0x3E77 while the key is armed (0 otherwise). All other bits read 0.
- R4: Writing 0x3E77 to bits [31:16] through offset 0x0 or 0x4 arms the key. A program request (op 3) starts only while the key is armed, and any program attempt disarms it. A program request with no key armed is ignored and raises no error.
- R5: An armed program request to a write-locked word gives no start and does not set busy. It sets error and disarms the key.
- R6: A shadow read (op 0) or fuse read (op 2) of a read-locked word returns 0xBADABADA on the access data output, gives no start, and sets error.
- R7: A shadow write (op 1) sets error when the word is write-locked, or when it arrives while a shadow reload is in progress.
- R8: While error is set, every request and every reload request is ignored. Error clears only through a 0x8 write with bit 9 set. Writing bit 9 through 0x0 or 0x4 does not change it.
- R9: An accepted fuse read or program sets busy until the engine done pulse. Any other request while busy gives no start.
- R10: Writing bit 10 from 0 to 1 while idle starts a reload (engine op 4) in the same cycle and sets busy and reload. Both clear on done. A reload request while busy or in error is ignored.
- R11: Each start carries the current address field on the engine address. Accepted shadow reads and writes (ops 0, 1) start without setting busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 4 | Byte offset of the register write (0x0, 0x4, 0x8) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current control word |
| acc_valid | input | 1 | Access request valid |
| acc_op | input | 2 | Request kind: 0 shadow read, 1 shadow write, 2 fuse read, 3 program |
| lk_rd | input | 1 | Addressed word is read-locked |
| lk_wr | input | 1 | Addressed word is write-locked |
| arr_rdata | input | 32 | Data read from the shadow or fuse array |
| acc_rdata | output | 32 | Read data returned to the requester |
| eng_start | output | 1 | Start pulse to the programming engine |
| eng_op | output | 3 | Operation started: ops 0 to 3 as requested, 4 for reload |
| eng_addr | output | 8 | Word address handed to the engine |
| eng_done | input | 1 | Engine finished the running operation |

## Verification
The start pulse, engine op and address, and the poisoned read data are combinational from the request and the current flags, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these outputs one time unit later. Flag and key changes land at the next rising edge, so the control word is read back one time unit after that edge. Every vector therefore consumes exactly one edge. After reset release, two extra edges pass through the synchronizer before the first vector is applied.

// File: rtl/otpc_pkg.sv
package otpc_pkg;
  typedef enum logic [2:0] {
    OP_SH_RD   = 3'd0,
    OP_SH_WR   = 3'd1,
    OP_FUSE_RD = 3'd2,
    OP_PROG    = 3'd3,
    OP_RELOAD  = 3'd4
  } otpc_op_e;

  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;
  localparam int KEY_LSB    = 16;
  localparam logic [3:0] OFF_DIR = 4'h0;
  localparam logic [3:0] OFF_SET = 4'h4;
  localparam logic [3:0] OFF_CLR = 4'h8;
endpackage

// File: rtl/otpc_alias.sv
module otpc_alias
  import otpc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY = 16'h3E77
) (
  input  logic              reg_wr,
  input  logic [3:0]        reg_off,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] cur_word,
  output logic              wr_hit,
  output logic [WORD_W-1:0] eff_word,
  output logic              key_arm,
  output logic              key_kill,
  output logic              err_clr,
  output logic              rl_req
);
  logic is_dir, is_set, is_clr;
  logic [KEY_W-1:0] wkey;

  assign is_dir = (reg_off == OFF_DIR);
  assign is_set = (reg_off == OFF_SET);
  assign is_clr = (reg_off == OFF_CLR);
  assign wr_hit = reg_wr & (is_dir | is_set | is_clr);
  assign wkey   = reg_wdata[KEY_LSB +: KEY_W];

  always_comb begin
    if (is_dir)      eff_word = reg_wdata;
    else if (is_set) eff_word = cur_word | reg_wdata;
    else             eff_word = cur_word & ~reg_wdata;
  end

  assign key_arm  = wr_hit & (is_dir | is_set) & (wkey == KEY);
  assign key_kill = wr_hit & ((is_dir & (wkey != KEY)) | (is_clr & (wkey != '0)));
  assign err_clr  = wr_hit & is_clr & reg_wdata[BIT_ERR];
  assign rl_req   = wr_hit & eff_word[BIT_RELOAD] & ~cur_word[BIT_RELOAD];
endmodule

// File: rtl/otpc_gate.sv
module otpc_gate
  import otpc_pkg::*;
(
  input  logic       acc_valid,
  input  logic [1:0] acc_op,
  input  logic       busy,
  input  logic       err,
  input  logic       reloading,
  input  logic       armed,
  input  logic       lk_rd,
  input  logic       lk_wr,
  input  logic       rl_req,
  output logic       go,
  output logic       set_busy,
  output logic       set_err,
  output logic       drop_key,
  output logic       rl_go,
  output logic       rd_poison
);
  otpc_op_e op;
  logic is_rd, lock_hit;

  assign op       = otpc_op_e'({1'b0, acc_op});
  assign is_rd    = (op == OP_SH_RD) | (op == OP_FUSE_RD);
  assign lock_hit = is_rd ? lk_rd : lk_wr;

  always_comb begin
    go       = 1'b0;
    set_err  = 1'b0;
    drop_key = 1'b0;
    if (acc_valid && !err) begin
      if (busy) begin
        set_err = (op == OP_SH_WR) & reloading;
      end else if (op == OP_PROG) begin
        if (armed) begin
          drop_key = 1'b1;
          set_err  = lk_wr;
          go       = ~lk_wr;
        end
      end else begin
        set_err = lock_hit;
        go      = ~lock_hit;
      end
    end
  end

  assign set_busy  = go & ((op == OP_FUSE_RD) | (op == OP_PROG));
  assign rl_go     = rl_req & ~busy & ~err & ~acc_valid;
  assign rd_poison = acc_valid & is_rd & lk_rd;
endmodule

// File: rtl/otpc_state.sv
module otpc_state #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              key_arm,
  input  logic              key_kill,
  input  logic              err_clr,
  input  logic              set_busy,
  input  logic              set_err,
  input  logic              drop_key,
  input  logic              rl_go,
  input  logic              eng_done,
  output logic [ADDR_W-1:0] addr_q,
  output logic              busy_q,
  output logic              err_q,
  output logic              rl_q,
  output logic              armed_q
);
  logic [1:0] rst_sync;
  logic       rst_ok;
  logic busy_d, err_d, rl_d, armed_d;
  logic busy_en, err_en, rl_en, armed_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  always_comb begin
    busy_en  = eng_done | set_busy | rl_go;
    busy_d   = set_busy | rl_go;
    rl_en    = eng_done | rl_go;
    rl_d     = rl_go;
    err_en   = err_clr | set_err;
    err_d    = set_err;
    armed_en = key_arm | key_kill | drop_key;
    armed_d  = key_arm & ~drop_key;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      addr_q  <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      rl_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (addr_we)  addr_q  <= addr_d;
      if (busy_en)  busy_q  <= busy_d;
      if (err_en)   err_q   <= err_d;
      if (rl_en)    rl_q    <= rl_d;
      if (armed_en) armed_q <= armed_d;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_ok)
    err_q && !err_clr |=> err_q); // R8
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_ok)
    set_err |=> err_q); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    busy_q && !eng_done |=> busy_q); // R9
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (set_busy || rl_go) |-> !busy_q && !err_q); // R9
  AST_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_ok)
    rl_q |-> busy_q); // R10
  AST_KEY_ONESHOT: assert property (@(posedge clk) disable iff (!rst_ok)
    drop_key |=> !armed_q); // R4
endmodule

// File: rtl/otpc_ctrl.sv
module otpc_ctrl
  import otpc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int KEY_W  = 16,
  parameter logic [KEY_W-1:0]  KEY    = 16'h3E77,
  parameter logic [WORD_W-1:0] POISON = 32'hBADABADA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_off,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_op,
  input  logic              lk_rd,
  input  logic              lk_wr,
  input  logic [WORD_W-1:0] arr_rdata,
  output logic [WORD_W-1:0] acc_rdata,
  output logic              eng_start,
  output logic [2:0]        eng_op,
  output logic [ADDR_W-1:0] eng_addr,
  input  logic              eng_done
);
  logic              wr_hit, key_arm, key_kill, err_clr, rl_req;
  logic [WORD_W-1:0] eff_word;
  logic              go, set_busy, set_err, drop_key, rl_go, rd_poison;
  logic [ADDR_W-1:0] addr_q;
  logic              busy_q, err_q, rl_q, armed_q;

  always_comb begin
    reg_rdata = '0;
    reg_rdata[ADDR_W-1:0]         = addr_q;
    reg_rdata[BIT_BUSY]           = busy_q;
    reg_rdata[BIT_ERR]            = err_q;
    reg_rdata[BIT_RELOAD]         = rl_q;
    reg_rdata[KEY_LSB +: KEY_W]   = armed_q ? KEY : '0;
  end

  otpc_alias #(.WORD_W(WORD_W), .KEY_W(KEY_W), .KEY(KEY)) u_alias (
    .reg_wr   (reg_wr),
    .reg_off  (reg_off),
    .reg_wdata(reg_wdata),
    .cur_word (reg_rdata),
    .wr_hit   (wr_hit),
    .eff_word (eff_word),
    .key_arm  (key_arm),
    .key_kill (key_kill),
    .err_clr  (err_clr),
    .rl_req   (rl_req)
  );

  otpc_gate u_gate (
    .acc_valid(acc_valid),
    .acc_op   (acc_op),
    .busy     (busy_q),
    .err      (err_q),
    .reloading(rl_q),
    .armed    (armed_q),
    .lk_rd    (lk_rd),
    .lk_wr    (lk_wr),
    .rl_req   (rl_req),
    .go       (go),
    .set_busy (set_busy),
    .set_err  (set_err),
    .drop_key (drop_key),
    .rl_go    (rl_go),
    .rd_poison(rd_poison)
  );

  otpc_state #(.ADDR_W(ADDR_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_we (wr_hit),
    .addr_d  (eff_word[ADDR_W-1:0]),
    .key_arm (key_arm),
    .key_kill(key_kill),
    .err_clr (err_clr),
    .set_busy(set_busy),
    .set_err (set_err),
    .drop_key(drop_key),
    .rl_go   (rl_go),
    .eng_done(eng_done),
    .addr_q  (addr_q),
    .busy_q  (busy_q),
    .err_q   (err_q),
    .rl_q    (rl_q),
    .armed_q (armed_q)
  );

  assign eng_start = go | rl_go;
  assign eng_op    = go ? {1'b0, acc_op} : OP_RELOAD;
  assign eng_addr  = addr_q;
  assign acc_rdata = rd_poison ? POISON : arr_rdata;
endmodule

// File: tb/sim_otpc_ctrl.sv
module sim_otpc_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_off;
  logic [31:0] reg_wdata, reg_rdata;
  logic        acc_valid;
  logic [1:0]  acc_op;
  logic        lk_rd, lk_wr;
  logic [31:0] arr_rdata, acc_rdata;
  logic        eng_start;
  logic [2:0]  eng_op;
  logic [7:0]  eng_addr;
  logic        eng_done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otpc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_op(acc_op), .lk_rd(lk_rd), .lk_wr(lk_wr), .arr_rdata(arr_rdata),
    .acc_rdata(acc_rdata), .eng_start(eng_start), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_done(eng_done)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [3:0]  off;
    logic [31:0] wd;
    logic        av;
    logic [1:0]  op;
    logic        lr;
    logic        lw;
    logic        dn;
    logic        xs;
    logic [2:0]  xop;
    logic [31:0] xrd;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b1, 4'h0, 32'h00000012, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000012}, // R2 direct
    '{4'd2,  1'b1, 4'h4, 32'h00000021, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000033}, // R2 set
    '{4'd2,  1'b1, 4'h8, 32'h00000003, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000030}, // R2 clear
    '{4'd2,  1'b1, 4'hC, 32'hFFFFFFFF, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000030}, // R2 bad offset
    '{4'd4,  1'b0, 4'h0, 32'h0,        1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000030}, // R4 no key
    '{4'd3,  1'b1, 4'h0, 32'h3E770045, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h3E770045}, // R3 key view
    '{4'd4,  1'b0, 4'h0, 32'h0,        1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 32'h00000145}, // R4 program
    '{4'd9,  1'b0, 4'h0, 32'h0,        1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000145}, // R9 busy reject
    '{4'd10, 1'b1, 4'h4, 32'h00000400, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000145}, // R10 reload busy
    '{4'd9,  1'b0, 4'h0, 32'h0,        1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h00000045}, // R9 done
    '{4'd4,  1'b0, 4'h0, 32'h0,        1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000045}, // R4 key used
    '{4'd11, 1'b0, 4'h0, 32'h0,        1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h00000045}, // R11 shadow rd
    '{4'd11, 1'b0, 4'h0, 32'h0,        1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 32'h00000045}, // R11 shadow wr
    '{4'd9,  1'b0, 4'h0, 32'h0,        1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h00000145}, // R9 fuse rd
    '{4'd9,  1'b0, 4'h0, 32'h0,        1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h00000045}, // R9 done
    '{4'd3,  1'b1, 4'h4, 32'h3E770000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h3E770045}, // R3 key via set
    '{4'd5,  1'b0, 4'h0, 32'h0,        1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00000245}, // R5 locked prog
    '{4'd8,  1'b1, 4'h0, 32'h00000045, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000245}, // R8 direct no clr
    '{4'd8,  1'b0, 4'h0, 32'h0,        1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000245}, // R8 blocked
    '{4'd10, 1'b1, 4'h4, 32'h00000400, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000245}, // R10 reload in err
    '{4'd8,  1'b1, 4'h8, 32'h00000200, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000045}, // R8 clear
    '{4'd6,  1'b0, 4'h0, 32'h0,        1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000245}, // R6 fuse rd lock
    '{4'd8,  1'b1, 4'h8, 32'h00000200, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000045}, // R8 clear
    '{4'd7,  1'b0, 4'h0, 32'h0,        1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00000245}, // R7 locked wr
    '{4'd8,  1'b1, 4'h8, 32'h00000200, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000045}, // R8 clear
    '{4'd10, 1'b1, 4'h4, 32'h00000400, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 32'h00000545}, // R10 reload
    '{4'd7,  1'b0, 4'h0, 32'h0,        1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000745}, // R7 wr in reload
    '{4'd10, 1'b0, 4'h0, 32'h0,        1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h00000245}, // R10 done
    '{4'd8,  1'b1, 4'h8, 32'h00000200, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000045}, // R8 clear
    '{4'd6,  1'b0, 4'h0, 32'h0,        1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000245}, // R6 shadow rd lock
    '{4'd8,  1'b1, 4'h8, 32'h00000200, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00000045}  // R8 clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr = 1'b0; reg_off = 4'h0; reg_wdata = '0;
    acc_valid = 1'b0; acc_op = 2'd0; lk_rd = 1'b0; lk_wr = 1'b0;
    arr_rdata = '0; eng_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    #1;
    check("R1 async reset", reg_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input bit wr, input logic [3:0] off, input logic [31:0] wd,
                      input bit av, input logic [1:0] op, input bit lr, input bit lw, input bit dn);
    @(negedge clk);
    reg_wr = wr; reg_off = off; reg_wdata = wd;
    acc_valid = av; acc_op = op; lk_rd = lr; lk_wr = lw; eng_done = dn;
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset word", reg_rdata, 32'h0);
    check("R1 no start", {31'b0, eng_start}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].off, VECS[i].wd, VECS[i].av, VECS[i].op,
           VECS[i].lr, VECS[i].lw, VECS[i].dn);
      check($sformatf("R%0d vec%0d start", VECS[i].req, i), {31'b0, eng_start}, {31'b0, VECS[i].xs});
      if (VECS[i].xs)
        check($sformatf("R%0d vec%0d op", VECS[i].req, i), {29'b0, eng_op}, {29'b0, VECS[i].xop});
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec%0d word", VECS[i].req, i), reg_rdata, VECS[i].xrd);
    end

    // R11: engine address at program start; R4 arming with new address
    step(1, 4'h0, 32'h3E77007E, 0, 2'd0, 0, 0, 0);
    step(0, 4'h0, 32'h0, 1, 2'd3, 0, 0, 0);
    check("R11 prog start", {31'b0, eng_start}, 32'h1);
    check("R11 eng addr", {24'b0, eng_addr}, 32'h7E);
    @(posedge clk); #1;
    check("R9 busy after prog", reg_rdata, 32'h0000017E);
    step(0, 4'h0, 32'h0, 0, 2'd0, 0, 0, 1);
    @(posedge clk); #1;
    check("R9 done clears", reg_rdata, 32'h0000007E);

    // R6: poison on locked read, pass-through otherwise
    step(0, 4'h0, 32'h0, 1, 2'd0, 0, 0, 0);
    arr_rdata = 32'h12345678; #1;
    check("R6 unlocked data", acc_rdata, 32'h12345678);
    lk_rd = 1'b1; #1;
    check("R6 poison data", acc_rdata, 32'hBADABADA);
    check("R6 no start", {31'b0, eng_start}, 32'h0);
    @(posedge clk); #1;
    step(1, 4'h8, 32'h00000200, 0, 2'd0, 0, 0, 0);
    @(posedge clk); #1;
    check("R8 clear again", reg_rdata, 32'h0000007E);

    // R8: set view cannot raise error; R4 clear view with key bits disarms
    step(1, 4'h4, 32'h3E770200, 0, 2'd0, 0, 0, 0);
    @(posedge clk); #1;
    check("R8 set cannot raise", reg_rdata, 32'h3E77007E);
    step(1, 4'h8, 32'h3E770000, 0, 2'd0, 0, 0, 0);
    @(posedge clk); #1;
    check("R4 clear disarms", reg_rdata, 32'h0000007E);

    // R1: reset from a busy state
    step(0, 4'h0, 32'h0, 1, 2'd2, 0, 0, 0);
    @(posedge clk); #1;
    check("R9 busy before reset", reg_rdata, 32'h0000017E);
    do_reset();
    #1;
    check("R1 reset from busy", reg_rdata, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule